// File: doc/BRIEF.md
# Serial path overhead REI-P inserter

This block feeds the remote error indication field of the outbound STS-1 SPE into the serial path overhead input of a framer. It runs on the overhead clock that the framer supplies and watches the framer's overhead enable and overhead frame strobes. It samples both strobes on every rising clock edge. When both are high at the same edge, the block arms and latches the REI-P value from its parallel input. It then counts a fixed gap of 28 clock periods and serializes the field onto its data output.

Data is launched on falling edges so that the framer can capture each bit on the rising edge that follows. The REI-P field is 4 bits wide and is sent most significant bit first, one bit per clock period. The parallel value usually comes from a receive-side parity error counter. The framer takes REI-P from this port only when its REI-P insertion-type field holds binary 10. That setting is a precondition for the system and is not a function of this block.

Top module: `poh_rei_inserter`

## Requirements
- R1: A frame start is taken only when `poh_en_i` and `poh_frm_i` are both 1 at the same rising edge. Either strobe alone has no effect.
- R2: Take the rising edge that detects a frame start as edge k. The first REI-P bit appears on `poh_data_o` at the falling edge that follows rising edge k+28. Before that falling edge the output stays 0.
- R3: The four bits are sent most significant bit first (bit 3, then 2, 1, 0), on four consecutive falling edges. The framer captures them at rising edges k+29 to k+32.
- R4: `poh_data_o` changes only on falling edges. It never changes across a rising edge.
- R5: `poh_data_o` is 0 outside the REI-P bit window. It is also 0 from reset until the first frame start.
- R6: `rei_val_i` is captured at edge k. Changes to it after edge k do not alter the frame being sent.
- R7: A frame start condition at rising edges k+1 to k+31 is ignored.
- R8: `busy_o` is 1 from edge k through edge k+32. At edge k+32 a frame start is accepted, which makes back-to-back frames possible. In that case `busy_o` stays 1.
- R9: The active-low asynchronous reset `rst_ni` puts the block back into idle, with `busy_o` = 0 and `poh_data_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Overhead clock from the framer |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poh_en_i | input | 1 | Overhead enable strobe from the framer |
| poh_frm_i | input | 1 | Overhead frame strobe from the framer |
| rei_val_i | input | 4 | REI-P value to transmit |
| poh_data_o | output | 1 | Serial overhead data, launched on falling edges |
| busy_o | output | 1 | High while a frame is armed or being sent |

## Verification
Two events can fall in the same cycle: the launch of the last REI-P bit completing at edge k+32, and a new frame start detected at that same edge. The bench raises both strobes exactly at edge k+32 and also at the edges just before it. The reference model must show that the starts at k+31 and earlier are dropped. It must also show that the start at k+32 begins a new frame with `busy_o` held high and a fresh 28-cycle gap. Random strobe traffic is added so that starts land on every offset inside a frame.

// File: rtl/poh_rei_pkg.sv
package poh_rei_pkg;
  localparam int unsigned WAIT_CYC_DEF = 28;
  localparam int unsigned REI_W_DEF    = 4;

  function automatic int unsigned cnt_width(input int unsigned span);
    return (span < 2) ? 1 : $clog2(span);
  endfunction
endpackage

// File: rtl/poh_rei_detect.sv
module poh_rei_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic frm_i,
  input  logic busy_i,
  input  logic done_i,
  output logic start_o
);
  logic coincident;

  assign coincident = en_i & frm_i;
  // accept when idle or on the final edge of the running frame
  assign start_o = coincident & (~busy_i | done_i);

  assert_single_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && frm_i) |-> !start_o);
endmodule

// File: rtl/poh_rei_seq.sv
module poh_rei_seq #(
  parameter int unsigned WAIT_CYC = 28,
  parameter int unsigned REI_W    = 4,
  parameter int unsigned CNT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [REI_W-1:0] rei_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             bit_vld_o,
  output logic             bit_o
);
  localparam int unsigned LAST = WAIT_CYC + REI_W - 1;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST);
  localparam logic [CNT_W-1:0] WAIT_C = CNT_W'(WAIT_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [REI_W-1:0] shf_q;

  assign done_o    = busy_q && (cnt_q == LAST_C);
  assign bit_vld_o = busy_q && (cnt_q >= WAIT_C);
  assign bit_o     = shf_q[REI_W-1];
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      shf_q  <= '0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
      shf_q  <= rei_i;
    end else if (busy_q) begin
      if (done_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (bit_vld_o) shf_q <= {shf_q[REI_W-2:0], 1'b0};
    end
  end

  assert_idle_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> !busy_q);
  assert_value_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && !bit_vld_o) |=> $stable(shf_q));
  assert_midframe_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  assert_end_or_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (busy_q == $past(start_i)));
endmodule

// File: rtl/poh_rei_launch.sv
module poh_rei_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic data_o
);
  logic data_q;

  // falling-edge launch gives the framer half a period of setup
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= 1'b0;
    else         data_q <= bit_vld_i & bit_i;
  end

  assign data_o = data_q;

  assert_low_outside_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |-> !data_q);
endmodule

// File: rtl/poh_rei_inserter.sv
module poh_rei_inserter
  import poh_rei_pkg::*;
#(
  parameter int unsigned WAIT_CYC = WAIT_CYC_DEF,
  parameter int unsigned REI_W    = REI_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             poh_en_i,
  input  logic             poh_frm_i,
  input  logic [REI_W-1:0] rei_val_i,
  output logic             poh_data_o,
  output logic             busy_o
);
  localparam int unsigned CNT_W = cnt_width(WAIT_CYC + REI_W);

  logic start, busy, done, bit_vld, bit_val;

  poh_rei_detect u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (poh_en_i),
    .frm_i  (poh_frm_i),
    .busy_i (busy),
    .done_i (done),
    .start_o(start)
  );

  poh_rei_seq #(
    .WAIT_CYC(WAIT_CYC),
    .REI_W   (REI_W),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .rei_i    (rei_val_i),
    .busy_o   (busy),
    .done_o   (done),
    .bit_vld_o(bit_vld),
    .bit_o    (bit_val)
  );

  poh_rei_launch u_launch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_vld_i(bit_vld),
    .bit_i    (bit_val),
    .data_o   (poh_data_o)
  );

  assign busy_o = busy;

  assert_reset_idle_R9: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !poh_data_o));
endmodule

// File: tb/poh_rei_inserter_test.sv
`timescale 1ns/100ps
module poh_rei_inserter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, frm = 1'b0;
  logic [3:0] rei = 4'h0;
  logic       data, busy;

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;

  // reference model: per-cycle queue of expected data bits
  bit q[$];
  bit exp_d, exp_b;
  string tag = "R5";

  always #2.5 clk = ~clk;

  poh_rei_inserter uut (
    .clk_i(clk), .rst_ni(rst_n), .poh_en_i(en), .poh_frm_i(frm),
    .rei_val_i(rei), .poh_data_o(data), .busy_o(busy)
  );

  task automatic check(input string t, input logic act, input logic expv, input string what);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", t, what, act, expv, $time);
    end
  endtask

  // one clock: drive after falling edge, compare before rising, recheck after
  task automatic cyc(input bit e, input bit f, input logic [3:0] v);
    @(negedge clk); #0.5;
    en = e; frm = f; rei = v;
    #1.5;
    exp_b = (q.size() != 0);
    exp_d = (q.size() != 0) ? q.pop_front() : 1'b0;
    check(tag, data, exp_d, "poh_data_o");
    check("R8", busy, exp_b, "busy_o");
    @(posedge clk); #0.5;
    check("R4", data, exp_d, "poh_data_o held over rising edge");
    if (rst_n && e && f && q.size() == 0) begin
      for (int i = 0; i < 28; i++) q.push_back(1'b0);
      for (int i = 3; i >= 0; i--) q.push_back(v[i]);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, rei);
  endtask

  initial begin
    #1.0;
    check("R9", busy, 1'b0, "busy_o in reset");
    check("R9", data, 1'b0, "poh_data_o in reset");
    @(negedge clk); #0.5; rst_n = 1'b1;
    tag = "R5"; idle(4);
    tag = "R1";
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 4'hF);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 4'hF);
    check("R1", busy, 1'b0, "busy_o after lone strobes");
    // single frame, value changed during the gap
    tag = "R2"; cyc(1'b1, 1'b1, 4'b1011);
    tag = "R6"; for (int i = 0; i < 27; i++) cyc(1'b0, 1'b0, 4'(i));
    tag = "R3"; idle(6);
    tag = "R5"; idle(3);
    // starts inside a running frame
    tag = "R7"; cyc(1'b1, 1'b1, 4'b0110);
    for (int i = 0; i < 31; i++) cyc(1'b1, 1'b1, 4'b1001);
    // edge k+32: accepted, back to back
    tag = "R8"; cyc(1'b1, 1'b1, 4'b1101);
    check("R8", busy, 1'b1, "busy_o kept by restart");
    idle(34);
    tag = "R3";
    for (int i = 0; i < 600; i++) cyc(($urandom % 3) == 0, ($urandom % 4) == 0, 4'($urandom));
    // asynchronous reset mid frame
    tag = "R9"; cyc(1'b1, 1'b1, 4'hF); idle(30);
    @(negedge clk); #0.3; rst_n = 1'b0; q.delete(); #0.4;
    check("R9", busy, 1'b0, "busy_o after reset");
    check("R9", data, 1'b0, "poh_data_o after reset");
    #1.0; rst_n = 1'b1;
    idle(8);
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done_flag) begin
      done_flag = 1;
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule